// File: doc/BRIEF.md
# Reloading Down-Counter Timer with Prescaler

This block is an 8-bit modulo-N down-counter that refills itself from a separate holding register. Each count event lowers the value by one. The event after the value 0x01 copies the holding register back into the counter and sends a one-cycle set pulse toward an interrupt latch that lives outside the block. Counting then carries on without a pause. A preset of 0x00 wraps through 0xFF, so the period between set pulses is a full 256 events.

Count events come from one of four sources, chosen when counting is started:
- rising edges of an external event pin;
- a divide-by-32 prescaler running on the clock;
- the prescaler, gated by one of two flag inputs.

In the two gated modes, the falling edge of the selected flag ends the measurement. It raises a set pulse and halts the counter, so the measured value can be read out. The pin and both flags are synchronized inside the block and edge-detected there.

Loading behaves differently depending on the state of the counter:
- **Stopped:** the data byte goes into both the counter and the holding register, and a clear pulse is sent to the interrupt latch.
- **Running:** only the holding register is written. The new value first appears at the next reload.

Top module: `rld_timer`

## Requirements
- R1: After reset, count_val is 0x00, running is 0, and irq_set and irq_clr are both 0.
- R2: Each count event lowers count_val by one, and 0x00 is followed by 0xFF. A preset of 0x00 therefore gives 256 events between set pulses.
- R3: A count event that finds count_val at 0x01 reloads it from the holding register and raises irq_set for one cycle. Later events keep decrementing.
- R4: cmd_load while stopped writes load_data into the counter and the holding register, and raises irq_clr for one cycle. irq_clr rises only in this case.
- R5: cmd_load while running writes only the holding register and does not raise irq_clr. The new value is used at the next reload.
- R6: If cmd_load while running coincides with a reload, the counter takes the new load_data.
- R7: While stopped (running = 0), count_val changes only through cmd_load.
- R8: cmd_start latches start_mode, encoded as follows:
  - 0: stopped
  - 1: count rising edges of ext_evt
  - 2: timer, one event per 32 clocks
  - 3: gated by flag_a
  - 4: gated by flag_b
  
  Codes 5 to 7 act as stopped. running is 1 in modes 1 to 4. cmd_stop has priority over cmd_start.
- R9: cmd_start clears the prescaler. In mode 2, the first decrement lands exactly 32 clocks after the edge that samples cmd_start.
- R10: In mode 3 or 4, the counter takes one event per 32 clocks during which the selected flag is high. The other flag has no effect.
- R11: In mode 3 or 4, a falling edge of the selected flag raises irq_set for one cycle and returns the block to the stopped state with count_val held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Load command, one cycle |
| load_data | input | 8 | Byte for the load command |
| cmd_stop | input | 1 | Stop command, one cycle |
| cmd_start | input | 1 | Start command, one cycle |
| start_mode | input | 3 | Mode code taken on cmd_start |
| ext_evt | input | 1 | Asynchronous external event pin |
| flag_a | input | 1 | Asynchronous gate flag for mode 3 |
| flag_b | input | 1 | Asynchronous gate flag for mode 4 |
| count_val | output | 8 | Current counter value |
| running | output | 1 | Counter active (mode 1 to 4) |
| irq_set | output | 1 | One-cycle set pulse to the interrupt latch |
| irq_clr | output | 1 | One-cycle clear pulse to the interrupt latch |

## Verification
A load issued while the counter is running can land in the same cycle as the reload at 0x01. In that case the counter must take the fresh byte rather than the stale holding value. The bench provokes this in timer mode: it loads 0x01 while stopped, starts the timer, and drives cmd_load exactly on the 32nd clock edge after the start. It then checks three things: the counter shows the new byte, exactly one irq_set pulse occurred, and no irq_clr pulse was raised.

// File: rtl/rld_timer_pkg.sv
package rld_timer_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_OFF    = 3'd0,
        MD_EVENT  = 3'd1,
        MD_TIMER  = 3'd2,
        MD_GATE_A = 3'd3,
        MD_GATE_B = 3'd4
    } mode_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_t;

    function automatic mode_e decode_mode(input logic [MODE_W-1:0] code);
        case (code)
            3'd1:    return MD_EVENT;
            3'd2:    return MD_TIMER;
            3'd3:    return MD_GATE_A;
            3'd4:    return MD_GATE_B;
            default: return MD_OFF;
        endcase
    endfunction

    function automatic logic is_gated(input mode_e m);
        return (m == MD_GATE_A) || (m == MD_GATE_B);
    endfunction

endpackage

// File: rtl/rld_sync_edge.sv
module rld_sync_edge
    import rld_timer_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_t ev
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign ev.level = chain[STAGES-1];
    assign ev.rise  = chain[STAGES-1] & ~prev;
    assign ev.fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/rld_prescaler.sv
module rld_prescaler #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    assign tick = en && !clr && (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= '0;
        end else if (en) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/rld_core.sv
module rld_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] ldata,
    output logic [W-1:0] count,
    output logic         set_pls,
    output logic         clr_pls
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] hold;
    logic [W-1:0] refill;

    // a running load in the reload cycle feeds the counter directly
    assign refill = load ? ldata : hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            hold    <= '0;
            set_pls <= 1'b0;
            clr_pls <= 1'b0;
        end else begin
            set_pls <= 1'b0;
            clr_pls <= 1'b0;
            if (load && !run) begin
                count   <= ldata;
                hold    <= ldata;
                clr_pls <= 1'b1;
            end else begin
                if (load) hold <= ldata;
                if (evt) begin
                    if (count == ONE) begin
                        count   <= refill;
                        set_pls <= 1'b1;
                    end else begin
                        count <= count - ONE;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rld_timer.sv
module rld_timer
    import rld_timer_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PRE_DIV   = 32,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_load,
    input  logic [CNT_W-1:0] load_data,
    input  logic             cmd_stop,
    input  logic             cmd_start,
    input  logic [2:0]       start_mode,
    input  logic             ext_evt,
    input  logic             flag_a,
    input  logic             flag_b,
    output logic [CNT_W-1:0] count_val,
    output logic             running,
    output logic             irq_set,
    output logic             irq_clr
);
    localparam int N_IN = 3;

    logic [N_IN-1:0] raw_in;
    edge_t           ev [N_IN];

    assign raw_in = {flag_b, flag_a, ext_evt};

    genvar gi;
    generate
        for (gi = 0; gi < N_IN; gi++) begin : g_sync
            rld_sync_edge #(.STAGES(SYNC_STGS)) sync_i (
                .clk (clk),
                .rst (rst),
                .din (raw_in[gi]),
                .ev  (ev[gi])
            );
        end
    endgenerate

    mode_e mode;
    logic  gate_end;
    logic  gate_lvl, gate_fall;
    logic  pre_en, pre_tick, cnt_evt;
    logic  core_set;

    always_comb begin
        gate_lvl  = 1'b0;
        gate_fall = 1'b0;
        if (mode == MD_GATE_A) begin
            gate_lvl  = ev[1].level;
            gate_fall = ev[1].fall;
        end else if (mode == MD_GATE_B) begin
            gate_lvl  = ev[2].level;
            gate_fall = ev[2].fall;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MD_OFF;
            gate_end <= 1'b0;
        end else begin
            gate_end <= 1'b0;
            if (cmd_stop) begin
                mode <= MD_OFF;
            end else if (cmd_start) begin
                mode <= decode_mode(start_mode);
            end else if (is_gated(mode) && gate_fall) begin
                mode     <= MD_OFF;
                gate_end <= 1'b1;
            end
        end
    end

    assign pre_en = (mode == MD_TIMER) || gate_lvl;

    rld_prescaler #(.DIV(PRE_DIV)) pre_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (cmd_start),
        .en   (pre_en),
        .tick (pre_tick)
    );

    always_comb begin
        case (mode)
            MD_EVENT: cnt_evt = ev[0].rise;
            MD_TIMER,
            MD_GATE_A,
            MD_GATE_B: cnt_evt = pre_tick;
            default:   cnt_evt = 1'b0;
        endcase
    end

    assign running = (mode != MD_OFF);

    rld_core #(.W(CNT_W)) core_i (
        .clk     (clk),
        .rst     (rst),
        .evt     (cnt_evt),
        .run     (running),
        .load    (cmd_load),
        .ldata   (load_data),
        .count   (count_val),
        .set_pls (core_set),
        .clr_pls (irq_clr)
    );

    assign irq_set = core_set | gate_end;
endmodule

// File: rtl/rld_timer_chk.sv
module rld_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_load,
    input logic [CNT_W-1:0] load_data,
    input logic             running,
    input logic [CNT_W-1:0] count_val,
    input logic             irq_set,
    input logic             irq_clr
);
    AST_LOAD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (cmd_load && !running) |=> (count_val == $past(load_data)) && irq_clr); // R4

    AST_CLR_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        irq_clr |-> ($past(cmd_load) && !$past(running))); // R4

    AST_RUN_LOAD_NO_CLR: assert property (@(posedge clk) disable iff (rst)
        (cmd_load && running) |=> !irq_clr); // R5

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!running && !cmd_load) |=> (count_val == $past(count_val))); // R7

    AST_SET_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
        irq_set |-> $past(running)); // R3
endmodule

bind rld_timer rld_timer_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/rld_timer_tb.sv
`timescale 1ns/1ps
module rld_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_load = 1'b0, cmd_stop = 1'b0, cmd_start = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic [2:0] start_mode = 3'd0;
    logic       ext_evt = 1'b0, flag_a = 1'b0, flag_b = 1'b0;
    logic [7:0] count_val;
    logic       running, irq_set, irq_clr;

    int errors = 0, checks = 0;
    int set_tot = 0, clr_tot = 0;
    int s0, c0;

    always #5 clk = ~clk;

    rld_timer dut_i (.*);

    always @(posedge clk) begin
        #1;
        if (!rst && irq_set) set_tot++;
        if (!rst && irq_clr) clr_tot++;
    end

    // {preset, events, expected count, expected set pulses} in event mode
    localparam logic [39:0] TBL [7] = '{
        {8'h05, 16'd3,   8'h02, 8'd0},
        {8'h05, 16'd5,   8'h05, 8'd1},
        {8'h05, 16'd7,   8'h03, 8'd1},
        {8'h00, 16'd1,   8'hFF, 8'd0},
        {8'h01, 16'd3,   8'h01, 8'd3},
        {8'h00, 16'd256, 8'h00, 8'd1},
        {8'h02, 16'd5,   8'h01, 8'd2}
    };

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic cmd(input logic st, input logic go, input logic [2:0] md,
                       input logic ld, input logic [7:0] d);
        @(negedge clk);
        cmd_stop = st; cmd_start = go; start_mode = md; cmd_load = ld; load_data = d;
        @(negedge clk);
        cmd_stop = 0; cmd_start = 0; cmd_load = 0;
    endtask

    task automatic pulse_ext(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_evt = 1;
            repeat (3) @(negedge clk);
            ext_evt = 0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic snap;
        s0 = set_tot; c0 = clr_tot;
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 count after reset", count_val, 0);
        chk("R1 running after reset", running, 0);
        chk("R1 set after reset", irq_set, 0);
        chk("R1 clr after reset", irq_clr, 0);
        rst = 0;
        @(negedge clk);

        // table walk in event mode (R2, R3, R8)
        foreach (TBL[k]) begin
            cmd(1, 0, 0, 0, 0);
            cmd(0, 0, 0, 1, TBL[k][39:32]);
            cmd(0, 1, 3'd1, 0, 0);
            snap();
            pulse_ext(int'(TBL[k][31:16]));
            chk($sformatf("R2 R3 vec%0d count", k), count_val, int'(TBL[k][15:8]));
            chk($sformatf("R3 vec%0d set pulses", k), set_tot - s0, int'(TBL[k][7:0]));
            chk($sformatf("R8 vec%0d running", k), running, 1);
        end

        // R4: load while stopped
        cmd(1, 0, 0, 0, 0);
        snap();
        cmd(0, 0, 0, 1, 8'h21);
        chk("R4 stopped load count", count_val, 8'h21);
        chk("R4 clr pulse", clr_tot - c0, 1);

        // R7: stopped ignores events
        pulse_ext(3);
        chk("R7 stopped count held", count_val, 8'h21);

        // R5: load while running
        cmd(0, 0, 0, 1, 8'h04);
        cmd(0, 1, 3'd1, 0, 0);
        pulse_ext(2);
        snap();
        cmd(0, 0, 0, 1, 8'h09);
        chk("R5 running load keeps count", count_val, 8'h02);
        chk("R5 running load no clr", clr_tot - c0, 0);
        pulse_ext(2);
        chk("R5 reload uses new hold", count_val, 8'h09);
        chk("R5 set pulse", set_tot - s0, 1);
        pulse_ext(1);
        chk("R3 continues after reload", count_val, 8'h08);

        // R9: timer mode, exact prescaler phase
        cmd(1, 0, 0, 0, 0);
        cmd(0, 0, 0, 1, 8'h03);
        snap();
        cmd(0, 1, 3'd2, 0, 0);
        repeat (63) @(negedge clk);
        chk("R9 before second tick", count_val, 8'h02);
        @(negedge clk);
        chk("R9 second tick", count_val, 8'h01);
        repeat (32) @(negedge clk);
        chk("R9 timer reload", count_val, 8'h03);
        chk("R9 timer set pulse", set_tot - s0, 1);
        repeat (10) @(negedge clk);
        cmd(0, 1, 3'd2, 0, 0);
        repeat (31) @(negedge clk);
        chk("R9 restart clears prescaler", count_val, 8'h03);
        @(negedge clk);
        chk("R9 tick after restart", count_val, 8'h02);

        // R6: running load coincides with reload
        cmd(1, 0, 0, 0, 0);
        cmd(0, 0, 0, 1, 8'h01);
        snap();
        @(negedge clk);
        cmd_start = 1; start_mode = 3'd2;
        @(negedge clk);
        cmd_start = 0;
        repeat (31) @(posedge clk);
        @(negedge clk);
        cmd_load = 1; load_data = 8'h07;
        @(negedge clk);
        cmd_load = 0;
        chk("R6 collision takes new byte", count_val, 8'h07);
        chk("R6 collision set pulse", set_tot - s0, 1);
        chk("R6 collision no clr", clr_tot - c0, 0);

        // R10 R11: gated on flag_a, flag_b ignored
        cmd(1, 0, 0, 0, 0);
        cmd(0, 0, 0, 1, 8'd100);
        cmd(0, 1, 3'd3, 0, 0);
        snap();
        flag_b = 1;
        repeat (80) @(negedge clk);
        flag_b = 0;
        repeat (6) @(negedge clk);
        chk("R10 other flag ignored", count_val, 100);
        chk("R10 still running", running, 1);
        flag_a = 1;
        repeat (106) @(negedge clk);
        flag_a = 0;
        repeat (6) @(negedge clk);
        chk("R10 gated count A", count_val, 97);
        chk("R11 end pulse A", set_tot - s0, 1);
        chk("R11 stopped after A", running, 0);

        // R10 R11: gated on flag_b
        cmd(0, 0, 0, 1, 8'd50);
        cmd(0, 1, 3'd4, 0, 0);
        snap();
        flag_b = 1;
        repeat (40) @(negedge clk);
        flag_b = 0;
        repeat (6) @(negedge clk);
        chk("R10 gated count B", count_val, 49);
        chk("R11 end pulse B", set_tot - s0, 1);
        chk("R11 stopped after B", running, 0);

        // R8: unused code acts as stopped, stop beats start
        cmd(0, 1, 3'd6, 0, 0);
        chk("R8 code 6 stopped", running, 0);
        cmd(1, 1, 3'd1, 0, 0);
        chk("R8 stop priority", running, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule